// File: doc/BRIEF.md
# Receive Frame Aggregator for a Bulk-In Link

This block sits between an Ethernet receive path and a full-speed style bulk-in endpoint. Each incoming frame arrives as a byte stream with start and end markers, and a status byte comes with the final byte. The frame's bytes include its 4-byte CRC. The block stores the whole frame so that it knows the frame length. It then sends a 3-byte prefix ahead of the stored bytes: the status byte, then the byte count as a little-endian 16-bit value. That count includes the CRC.

Frames that are already waiting when the previous frame finishes are packed into the same transfer, as long as the transfer stays within its byte budget. The output stream is cut into fixed-size packets. A transfer ends on a short packet, and when the transfer length is an exact multiple of the packet size, an explicit zero-length packet beat ends it. Oversize frames and bytes that arrive outside a frame are discarded. Both sides use a valid/ready handshake.

Top module: `rx_frame_encap`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Each forwarded frame appears on the output in this order: its status byte, the length low byte, the length high byte, and then every input byte of the frame in arrival order. The length is the number of input bytes of the frame, which is payload plus 4 CRC bytes.
- R3: The status byte is taken from `in_status` on the beat that carries `in_eof` and is forwarded unchanged, whether it is the good-frame value 0x40 or any other value.
- R4: A frame of more than 1518 input bytes (payload above 1514 bytes) is discarded completely. A frame of exactly 1518 bytes is forwarded.
- R5: Bytes accepted while no frame is open (no `in_sof` since the last `in_eof`) are discarded.
- R6: On the last byte of a frame, if the next stored frame (length L) makes the transfer total of prefix plus frame bytes no more than 3072, that frame continues the same transfer. Otherwise the transfer closes there. A transfer never exceeds 3072 bytes.
- R7: When no further frame is stored at the last byte of a frame, the transfer closes on that byte.
- R8: `out_pkt_end` is 1 on every 64th byte of a transfer and on the final byte of a transfer, and is 0 on every other data beat.
- R9: A transfer whose length is a multiple of 64 is followed by one extra beat with `out_zlp`=1, `out_pkt_end`=1 and `out_data`=0x00. No other beat has `out_zlp`=1.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output beat is held unchanged. Under any `out_ready` pattern, no byte is lost or repeated.
- R11: `in_ready` goes to 0 when 8 completed frames are waiting in the queue or when the byte store is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte (payload and CRC) |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_status | input | 8 | Frame status, sampled with `in_eof` |
| in_ready | output | 1 | Block can accept an input byte |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Output stream byte |
| out_pkt_end | output | 1 | Last beat of a packet |
| out_zlp | output | 1 | Beat stands for a zero-length packet |
| out_ready | input | 1 | Downstream accepts the beat |

## Verification
The bench builds transfers whose totals land exactly on 3072 bytes and one byte beyond that. A design with an off-by-one fit test would either overrun the budget or split too early, and would also get the zero-length packet marker wrong. Frames of 1518 and 1519 bytes, and stray bytes sent before a start marker, test the discard paths: a lax design would leak bytes into the stream, and a strict one would lose the largest legal frame. Long stalls and a toggling `out_ready` expose any lost or repeated byte. Queueing nine frames behind a stalled output checks that input back-pressure rises once the length queue fills.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PK_IDLE,
    PK_LENLO,
    PK_LENHI,
    PK_DATA,
    PK_ZLP
  } pk_state_t;
endpackage

// File: rtl/rfe_ram.sv
module rfe_ram #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rfe_len_fifo.sv
module rfe_len_fifo #(
  parameter int W     = 19,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] slot [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
  assign dout  = slot[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) slot[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + (AW+1)'(1);
      if (pop)  rp <= rp + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/rfe_writer.sv
module rfe_writer #(
  parameter int BUF_DEPTH = 4096,
  parameter int MAX_FRAME = 1518,
  localparam int AW    = $clog2(BUF_DEPTH),
  localparam int PW    = AW + 1,
  localparam int LEN_W = $clog2(MAX_FRAME + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_status,
  output logic             in_ready,
  input  logic [PW-1:0]    rd_ptr,
  input  logic             lq_full,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [7:0]       ram_wdata,
  output logic             lq_push,
  output logic [LEN_W+7:0] lq_din
);
  logic [PW-1:0]    frm_start, wr_cur, used, b_base;
  logic [LEN_W-1:0] cnt, b_cnt;
  logic             drop_q, in_frame, take, b_drop;

  assign used     = wr_cur - rd_ptr;
  assign in_ready = !lq_full && (drop_q || (used != PW'(BUF_DEPTH)));
  assign take     = in_valid && in_ready && (in_sof || in_frame);

  always_comb begin
    b_base = in_sof ? frm_start : wr_cur;
    if (in_sof)      b_cnt = LEN_W'(1);
    else if (drop_q) b_cnt = cnt;
    else             b_cnt = cnt + LEN_W'(1);
    b_drop = (!in_sof && drop_q) || (b_cnt > LEN_W'(MAX_FRAME));
  end

  assign ram_we    = take && !b_drop;
  assign ram_waddr = b_base[AW-1:0];
  assign ram_wdata = in_data;
  assign lq_push   = take && in_eof && !b_drop;
  assign lq_din    = {in_status, b_cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_start <= '0;
      wr_cur    <= '0;
      cnt       <= '0;
      drop_q    <= 1'b0;
      in_frame  <= 1'b0;
    end else if (take) begin
      cnt      <= b_cnt;
      in_frame <= !in_eof;
      if (in_eof) begin
        drop_q <= 1'b0;
        if (!b_drop) begin
          frm_start <= b_base + PW'(1);
          wr_cur    <= b_base + PW'(1);
        end else begin
          wr_cur <= frm_start;
        end
      end else begin
        drop_q <= b_drop;
        if (!b_drop) wr_cur <= b_base + PW'(1);
      end
    end
  end
endmodule

// File: rtl/rfe_packer.sv
module rfe_packer
  import rfe_pkg::*;
#(
  parameter int BUF_DEPTH = 4096,
  parameter int MAX_FRAME = 1518,
  parameter int XFER_MAX  = 3072,
  parameter int PKT_SIZE  = 64,
  localparam int AW    = $clog2(BUF_DEPTH),
  localparam int PW    = AW + 1,
  localparam int LEN_W = $clog2(MAX_FRAME + 2),
  localparam int XW    = $clog2(XFER_MAX + 1),
  localparam int PCW   = $clog2(PKT_SIZE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lq_empty,
  input  logic [LEN_W+7:0] lq_dout,
  output logic             lq_pop,
  input  logic [7:0]       ram_rdata,
  output logic [AW-1:0]    ram_raddr,
  output logic [PW-1:0]    rd_ptr,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_pkt_end,
  output logic             out_zlp,
  input  logic             out_ready
);
  pk_state_t        state;
  logic [LEN_W-1:0] cur_len, rem, head_len;
  logic [7:0]       head_st;
  logic [15:0]      len16;
  logic [XW-1:0]    xfer_cnt;
  logic [PCW-1:0]   pkt_cnt;
  logic [PW-1:0]    rd_ptr_next;
  logic [31:0]      fit_sum;
  logic             load, emit, zlp_emit, pkt_full, close_c, last_byte;
  logic [7:0]       beat_byte;

  assign head_len  = lq_dout[LEN_W-1:0];
  assign head_st   = lq_dout[LEN_W+7:LEN_W];
  assign len16     = 16'(cur_len);
  assign load      = !out_valid || out_ready;
  assign pkt_full  = (pkt_cnt == PCW'(PKT_SIZE - 1));
  assign last_byte = (state == PK_DATA) && (rem == LEN_W'(1));
  assign fit_sum   = 32'(xfer_cnt) + 32'(head_len) + 32'd4;
  assign close_c   = last_byte && (lq_empty || (fit_sum > 32'(XFER_MAX)));

  always_comb begin
    emit      = 1'b0;
    zlp_emit  = 1'b0;
    beat_byte = 8'h00;
    if (load) begin
      unique case (state)
        PK_IDLE:  begin emit = !lq_empty; beat_byte = head_st;      end
        PK_LENLO: begin emit = 1'b1;      beat_byte = len16[7:0];   end
        PK_LENHI: begin emit = 1'b1;      beat_byte = len16[15:8];  end
        PK_DATA:  begin emit = 1'b1;      beat_byte = ram_rdata;    end
        PK_ZLP:   begin zlp_emit = 1'b1;  beat_byte = 8'h00;        end
        default:  begin emit = 1'b0;                                end
      endcase
    end
  end

  assign lq_pop      = emit && (state == PK_IDLE);
  assign rd_ptr_next = rd_ptr + PW'(emit && (state == PK_DATA));
  assign ram_raddr   = rd_ptr_next[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PK_IDLE;
      rd_ptr      <= '0;
      cur_len     <= '0;
      rem         <= '0;
      xfer_cnt    <= '0;
      pkt_cnt     <= '0;
      out_valid   <= 1'b0;
      out_data    <= 8'h00;
      out_pkt_end <= 1'b0;
      out_zlp     <= 1'b0;
    end else begin
      rd_ptr <= rd_ptr_next;
      if (load) begin
        out_valid   <= emit || zlp_emit;
        out_data    <= beat_byte;
        out_pkt_end <= zlp_emit || (emit && (pkt_full || close_c));
        out_zlp     <= zlp_emit;
      end
      if (emit) begin
        pkt_cnt  <= (pkt_full || close_c) ? '0 : pkt_cnt + PCW'(1);
        xfer_cnt <= close_c ? '0 : xfer_cnt + XW'(1);
      end
      if (load) begin
        unique case (state)
          PK_IDLE: if (!lq_empty) begin
            cur_len <= head_len;
            rem     <= head_len;
            state   <= PK_LENLO;
          end
          PK_LENLO: state <= PK_LENHI;
          PK_LENHI: state <= PK_DATA;
          PK_DATA: begin
            rem <= rem - LEN_W'(1);
            if (last_byte) state <= (close_c && pkt_full) ? PK_ZLP : PK_IDLE;
          end
          PK_ZLP:  state <= PK_IDLE;
          default: state <= PK_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_frame_encap.sv
module rx_frame_encap #(
  parameter int BUF_DEPTH = 4096,
  parameter int MAX_FRAME = 1518,
  parameter int XFER_MAX  = 3072,
  parameter int PKT_SIZE  = 64,
  parameter int LQ_DEPTH  = 8,
  localparam int AW    = $clog2(BUF_DEPTH),
  localparam int PW    = AW + 1,
  localparam int LEN_W = $clog2(MAX_FRAME + 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_status,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_pkt_end,
  output logic       out_zlp,
  input  logic       out_ready
);
  logic             ram_we;
  logic [AW-1:0]    ram_waddr, ram_raddr;
  logic [7:0]       ram_wdata, ram_rdata;
  logic [PW-1:0]    rd_ptr;
  logic             lq_push, lq_pop, lq_empty, lq_full;
  logic [LEN_W+7:0] lq_din, lq_dout;

  rfe_writer #(.BUF_DEPTH(BUF_DEPTH), .MAX_FRAME(MAX_FRAME)) u_writer (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_status(in_status), .in_ready(in_ready),
    .rd_ptr(rd_ptr), .lq_full(lq_full),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .lq_push(lq_push), .lq_din(lq_din)
  );

  rfe_ram #(.DEPTH(BUF_DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  rfe_len_fifo #(.W(LEN_W + 8), .DEPTH(LQ_DEPTH)) u_lq (
    .clk(clk), .rst(rst), .push(lq_push), .din(lq_din), .pop(lq_pop),
    .dout(lq_dout), .empty(lq_empty), .full(lq_full)
  );

  rfe_packer #(
    .BUF_DEPTH(BUF_DEPTH), .MAX_FRAME(MAX_FRAME),
    .XFER_MAX(XFER_MAX), .PKT_SIZE(PKT_SIZE)
  ) u_packer (
    .clk(clk), .rst(rst),
    .lq_empty(lq_empty), .lq_dout(lq_dout), .lq_pop(lq_pop),
    .ram_rdata(ram_rdata), .ram_raddr(ram_raddr), .rd_ptr(rd_ptr),
    .out_valid(out_valid), .out_data(out_data), .out_pkt_end(out_pkt_end),
    .out_zlp(out_zlp), .out_ready(out_ready)
  );
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int XFER_MAX = 3072,
  parameter int PKT_SIZE = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_pkt_end,
  input logic       out_zlp
);
  logic [15:0] pkt_n, xfer_n;
  logic        last_full;
  logic        fire;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_n     <= '0;
      xfer_n    <= '0;
      last_full <= 1'b0;
    end else if (fire) begin
      if (out_zlp) begin
        pkt_n     <= '0;
        xfer_n    <= '0;
        last_full <= 1'b0;
      end else if (out_pkt_end) begin
        pkt_n     <= '0;
        last_full <= (pkt_n + 16'd1 == 16'(PKT_SIZE));
        xfer_n    <= (pkt_n + 16'd1 < 16'(PKT_SIZE)) ? '0 : xfer_n + 16'd1;
      end else begin
        pkt_n  <= pkt_n + 16'd1;
        xfer_n <= xfer_n + 16'd1;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_pkt_end) && $stable(out_zlp)); // R10

  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_zlp && (pkt_n == 16'(PKT_SIZE - 1)) |-> out_pkt_end); // R8

  AST_XFER_LIMIT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_zlp |-> xfer_n < 16'(XFER_MAX)); // R6

  AST_ZLP_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_zlp |-> last_full && (pkt_n == 16'd0) && out_pkt_end); // R9
endmodule

bind rx_frame_encap rfe_checker #(.XFER_MAX(XFER_MAX), .PKT_SIZE(PKT_SIZE)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_pkt_end(out_pkt_end), .out_zlp(out_zlp)
);

// File: tb/tb_rx_frame_encap.sv
`timescale 1ns/1ps
module tb_rx_frame_encap;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00, in_status = 8'h00;
  logic       in_ready, out_valid, out_pkt_end, out_zlp;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  int n_chk = 0, n_bad = 0;
  int rmode = 0;
  logic [9:0] exp_q[$];
  logic [7:0] grp[$];
  int fl[16], fs[16], fd[16];
  int nf = 0;

  always #2.5 clk = ~clk;

  rx_frame_encap dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_status(in_status), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_pkt_end(out_pkt_end),
    .out_zlp(out_zlp), .out_ready(out_ready)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // out_ready driver: 0 = always ready, 1 = stalled, 2 = toggling
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'b0 : ((cyc % 3) != 0);
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      logic [9:0] got, e;
      got = {out_zlp, out_pkt_end, out_data};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected beat actual=0x%0h expected=none", got);
      end else begin
        e = exp_q.pop_front();
        if (got != e) begin
          n_bad++;
          if (got[9] != e[9])      $display("FAIL R9 zlp actual=0x%0h expected=0x%0h", got, e);
          else if (got[8] != e[8]) $display("FAIL R8 pkt_end actual=0x%0h expected=0x%0h", got, e);
          else                     $display("FAIL R2 byte actual=0x%0h expected=0x%0h", got, e);
        end
      end
    end
  end

  task automatic send_beat();
    bit ok;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
  endtask

  task automatic drive_frame(input int len, input int st, input int seed);
    for (int i = 0; i < len; i++) begin
      in_valid  = 1'b1;
      in_data   = 8'(seed + i * 7);
      in_sof    = (i == 0);
      in_eof    = (i == len - 1);
      in_status = (i == len - 1) ? 8'(st) : 8'h00;
      send_beat();
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic add_frame(input int len, input int st, input int seed);
    fl[nf] = len; fs[nf] = st; fd[nf] = seed; nf++;
    drive_frame(len, st, seed);
  endtask

  task automatic emit_group();
    int n = grp.size();
    for (int k = 0; k < n; k++)
      exp_q.push_back({1'b0, (((k + 1) % 64) == 0) || (k == n - 1), grp[k]});
    if (n > 0 && (n % 64) == 0) exp_q.push_back({1'b1, 1'b1, 8'h00});
    grp.delete();
  endtask

  // greedy packing of all recorded frames, budget 3072 bytes per transfer
  task automatic model_flush();
    int x = 0;
    for (int i = 0; i < nf; i++) begin
      if (x + fl[i] + 3 > 3072) begin emit_group(); x = 0; end
      grp.push_back(8'(fs[i]));
      grp.push_back(8'(fl[i]));
      grp.push_back(8'(fl[i] >> 8));
      for (int j = 0; j < fl[i]; j++) grp.push_back(8'(fd[i] + j * 7));
      x += fl[i] + 3;
    end
    emit_group();
    nf = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (20) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", out_valid, 0);
    check("R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // R2 R7 R8: lone 60-byte frame, 63-byte transfer, short packet end
    add_frame(60, 8'h40, 3); model_flush(); drain();

    // R3 R9: 61 bytes gives 64-byte transfer, then zero-length beat
    add_frame(61, 8'h00, 17); model_flush(); drain();

    // R5: stray bytes before any start marker are dropped
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_data = 8'hEE; in_sof = 1'b0; in_eof = 1'b0;
      send_beat();
    end
    in_valid = 1'b0;
    add_frame(10, 8'h40, 90); model_flush(); drain();

    // R4: 1519-byte frame discarded, following frame intact
    drive_frame(1519, 8'h40, 5);
    add_frame(20, 8'h22, 44); model_flush(); drain();

    // R6 R9 R10 R4: 1518+1518+27 => exactly 3072 bytes, then ZLP
    rmode = 1;
    add_frame(1518, 8'h40, 1);
    add_frame(1518, 8'h11, 2);
    add_frame(27, 8'h40, 9);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R10 held beat valid", out_valid, 1);
    check("R10 held beat is first status", out_data, 8'h40);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 beat still held", {out_valid, out_data}, {1'b1, 8'h40});
    model_flush();
    rmode = 2; drain();

    // R6: 1518+1518+28 => 3073 would overflow, so the transfer splits
    rmode = 1;
    add_frame(1518, 8'h40, 6);
    add_frame(1518, 8'h40, 7);
    add_frame(28, 8'h40, 8);
    model_flush();
    rmode = 0; drain();

    // R11: nine 400-byte frames behind a stalled output fill the queue
    rmode = 1;
    for (int i = 0; i < 9; i++) add_frame(400, 8'h40, 20 + i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 in_ready low with queue full", in_ready, 0);
    model_flush();
    rmode = 2; drain();
    @(negedge clk);
    check("R11 in_ready back high", in_ready, 1);
    check("R10 no leftover expected beats", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule